// File: doc/BRIEF.md
# Serial Receive FIFO Front End with Trigger-Level Interrupt

This block is the register-mapped receive and status front end of a serial port that buffers incoming bytes. A line-side deserialiser hands it whole bytes with a valid strobe, plus a break indication. The block holds them in a receive FIFO, 16 entries deep by default. It sets a data-full flag once the number of buffered bytes reaches a programmable trigger count. When enabled, it raises a receive interrupt at the same point, so software can drain a burst of bytes instead of taking one interrupt per byte.

On the bus side there is one byte-wide access per cycle, selected by a 3-bit register select. Read data is combinational for the selected register, and any side effect of the access (a pop, or the setting of a flag) takes place at the clock edge that ends it. The block keeps the port's mode, control and port registers with fixed write masks. It passes transmit bytes straight out to the line with a one-cycle strobe. The status flags are cleared by writing zeros to them. Bit-level serialisation, baud generation and a transmit FIFO belong to neighbouring blocks.

Top module: `serial_rx_trigger_port`

## Requirements
- R1: The receive FIFO holds DEPTH (16) bytes and returns them in arrival order. A byte that arrives while the FIFO already holds DEPTH bytes is dropped.
- R2: When an accepted byte brings the FIFO count to or above the trigger level, status bit 1 (data-full) is set. If control bit 6 (receive interrupt enable) is set, `irq_rx` is also asserted.
- R3: Each read of the receive data register pops one byte. When a pop leaves the count below the trigger level, data-full clears. A read of an empty FIFO returns the most recently popped byte and leaves the FIFO unchanged.
- R4: Bytes from the line are accepted only while control bit 4 (receive enable) is set. Otherwise `rx_valid` has no effect.
- R5: A control write with bit 5 (transmit enable) at 0 sets status bit 6 (transmit end). `irq_tx` follows stored control bit 7. A control write with bit 6 at 0 deasserts `irq_rx`.
- R6: In a status write, a 0 clears the flag at that position: bit 6 transmit end, bit 5 transmit-data empty, bit 4 break, bit 1 data-full, bit 0 data-ready. A 1 leaves the flag unchanged. A 0 in bit 1 or bit 0 also deasserts `irq_rx`. Status reads return {0, tend, tde, brk, 0, 0, rdf, dr}. `rx_break` sets the break flag, and every accepted byte sets data-ready.
- R7: FIFO control bits 7:6 select the trigger level: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. Writing FIFO control bit 1 as 1 empties the FIFO; that bit is not stored.
- R8: Stored values are masked on write: mode with 0x7B, control with 0xFA, port with 0xF3 and FIFO control with 0xFD. Each reads back its stored value.
- R9: A transmit data write puts the byte on `tx_byte`, raises `tx_strobe` for the one cycle after the write, and clears transmit-data empty. A status read while control bit 5 is set sets transmit-data empty and transmit end after the read. The read itself returns the flags as they were.
- R10: After reset, status reads 0x60, control reads 0x20, mode, port and FIFO control read 0, and both interrupt lines are low.
- R11: Register select codes are: 0 mode, 1 control, 2 transmit data, 3 receive data, 4 status, 5 FIFO control, 6 port. A cycle with both `wr_en` and `rd_en` high is treated as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; side effects at the clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break detected on the line |
| tx_byte | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle strobe for tx_byte |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
On every cycle the assertions check several invariants. The FIFO count never exceeds its depth, and a byte offered to a full FIFO leaves the count unchanged. Data-full rises whenever a push reaches the trigger level, and `irq_rx` is never high while its enable is off. With receive disabled the count never grows, and the transmit strobe and `irq_tx` follow the preceding writes. Byte order through the FIFO, the read-back of the last byte on an empty read, each trigger encoding, the write masks and the write-zero clearing of each flag can only be shown by the bench's directed and random scenarios against its own model.

// File: rtl/srx_pkg.sv
package srx_pkg;
   localparam int BYTE_W = 8;

   // register selects (R11)
   localparam logic [2:0] SEL_MODE = 3'd0;
   localparam logic [2:0] SEL_CTRL = 3'd1;
   localparam logic [2:0] SEL_TXD  = 3'd2;
   localparam logic [2:0] SEL_RXD  = 3'd3;
   localparam logic [2:0] SEL_STAT = 3'd4;
   localparam logic [2:0] SEL_FCTL = 3'd5;
   localparam logic [2:0] SEL_PORT = 3'd6;

   // control bits
   localparam int CTRL_TIE = 7;
   localparam int CTRL_RIE = 6;
   localparam int CTRL_TE  = 5;
   localparam int CTRL_RE  = 4;

   // status bits
   localparam int ST_TEND = 6;
   localparam int ST_TDE  = 5;
   localparam int ST_BRK  = 4;
   localparam int ST_RDF  = 1;
   localparam int ST_DR   = 0;

   localparam int FCTL_FLUSH = 1;

   localparam logic [BYTE_W-1:0] MODE_MASK  = 8'h7B;
   localparam logic [BYTE_W-1:0] CTRL_MASK  = 8'hFA;
   localparam logic [BYTE_W-1:0] PORT_MASK  = 8'hF3;
   localparam logic [BYTE_W-1:0] FCTL_MASK  = 8'hFD;
   localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          flush,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          push_ok,
   output logic          pop_ok
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("srx_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("srx_fifo: W must be at least 1");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] head_q, tail_q, head_inc, tail_inc;
   logic [CW-1:0] count_q;

   assign push_ok = push && (count_q < CW'(DEPTH)) && !flush;
   assign pop_ok  = pop && (count_q != '0) && !flush;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign head_inc = head_q + 1'b1;
      assign tail_inc = tail_q + 1'b1;
   end else begin : g_wrap
      assign head_inc = (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
      assign tail_inc = (tail_q == PW'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[head_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else if (flush) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (push_ok) head_q <= head_inc;
         if (pop_ok)  tail_q <= tail_inc;
         count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   assign dout  = mem_q[tail_q];
   assign count = count_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH)); // R1
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CW'(DEPTH)) && push && !pop && !flush |=> count_q == CW'(DEPTH)); // R1
endmodule

// File: rtl/srx_trigger.sv
module srx_trigger #(
   parameter int DEPTH = 16,
   parameter int CW    = $clog2(DEPTH + 1),
   parameter int LVL0  = 1,
   parameter int LVL1  = 4,
   parameter int LVL2  = 8,
   parameter int LVL3  = 14
) (
   input  logic [1:0]    trig_sel,
   input  logic [CW-1:0] cnt,
   output logic          at_level
);
   localparam int LVL_TAB [4] = '{LVL0, LVL1, LVL2, LVL3};

   for (genvar g = 0; g < 4; g++) begin : g_chk
      if (LVL_TAB[g] < 1 || LVL_TAB[g] > DEPTH) begin : g_bad
         $error("srx_trigger: trigger level out of range");
      end
   end

   logic [CW-1:0] level;

   always_comb begin
      case (trig_sel)
         2'd0:    level = CW'(LVL0);
         2'd1:    level = CW'(LVL1);
         2'd2:    level = CW'(LVL2);
         default: level = CW'(LVL3);
      endcase
   end

   assign at_level = cnt >= level;
endmodule

// File: rtl/serial_rx_trigger_port.sv
module serial_rx_trigger_port
   import srx_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL0  = 1,
   parameter int LVL1  = 4,
   parameter int LVL2  = 8,
   parameter int LVL3  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_sel,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_break,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              tx_strobe,
   output logic              irq_rx,
   output logic              irq_tx
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [BYTE_W-1:0] mode_q, ctrl_q, fctl_q, port_q, last_q, tx_byte_q, ctrl_nx;
   logic              tend_q, tde_q, brk_q, rdf_q, dr_q, irq_rx_q, tx_stb_q;
   logic              rd, wr_ctrl, wr_stat, rd_stat, rd_rxd, flush;
   logic              push_ok, pop_ok, at_trig;
   logic [BYTE_W-1:0] fifo_dout, stat_val;
   logic [CW-1:0]     count, count_nx;

   assign rd      = rd_en && !wr_en;
   assign wr_ctrl = wr_en && (reg_sel == SEL_CTRL);
   assign wr_stat = wr_en && (reg_sel == SEL_STAT);
   assign rd_stat = rd && (reg_sel == SEL_STAT);
   assign rd_rxd  = rd && (reg_sel == SEL_RXD);
   assign flush   = wr_en && (reg_sel == SEL_FCTL) && wr_data[FCTL_FLUSH];
   assign ctrl_nx = wr_ctrl ? (wr_data & CTRL_MASK) : ctrl_q;

   srx_fifo #(.W(BYTE_W), .DEPTH(DEPTH), .CW(CW)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (rx_valid && ctrl_q[CTRL_RE]),
      .pop     (rd_rxd),
      .flush   (flush),
      .din     (rx_byte),
      .dout    (fifo_dout),
      .count   (count),
      .push_ok (push_ok),
      .pop_ok  (pop_ok)
   );

   assign count_nx = count + CW'(push_ok) - CW'(pop_ok);

   srx_trigger #(.DEPTH(DEPTH), .CW(CW), .LVL0(LVL0), .LVL1(LVL1),
                 .LVL2(LVL2), .LVL3(LVL3)) u_trig (
      .trig_sel (fctl_q[7:6]),
      .cnt      (count_nx),
      .at_level (at_trig)
   );

   assign stat_val = {1'b0, tend_q, tde_q, brk_q, 2'b00, rdf_q, dr_q};

   always_comb begin
      case (reg_sel)
         SEL_MODE: rd_data = mode_q;
         SEL_CTRL: rd_data = ctrl_q;
         SEL_RXD:  rd_data = (count != '0) ? fifo_dout : last_q;
         SEL_STAT: rd_data = stat_val;
         SEL_FCTL: rd_data = fctl_q;
         SEL_PORT: rd_data = port_q;
         default:  rd_data = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         ctrl_q    <= CTRL_RESET;
         fctl_q    <= '0;
         port_q    <= '0;
         last_q    <= '0;
         tx_byte_q <= '0;
         tx_stb_q  <= 1'b0;
         tend_q    <= 1'b1;
         tde_q     <= 1'b1;
         brk_q     <= 1'b0;
         rdf_q     <= 1'b0;
         dr_q      <= 1'b0;
         irq_rx_q  <= 1'b0;
      end else begin
         tx_stb_q <= 1'b0;
         if (wr_en) begin
            case (reg_sel)
               SEL_MODE: mode_q <= wr_data & MODE_MASK;
               SEL_CTRL: begin
                  ctrl_q <= wr_data & CTRL_MASK;
                  if (!wr_data[CTRL_TE])  tend_q   <= 1'b1;
                  if (!wr_data[CTRL_RIE]) irq_rx_q <= 1'b0;
               end
               SEL_TXD: begin
                  tx_byte_q <= wr_data;
                  tx_stb_q  <= 1'b1;
                  tde_q     <= 1'b0;
               end
               SEL_STAT: begin
                  tend_q <= tend_q & wr_data[ST_TEND];
                  tde_q  <= tde_q  & wr_data[ST_TDE];
                  brk_q  <= brk_q  & wr_data[ST_BRK];
                  rdf_q  <= rdf_q  & wr_data[ST_RDF];
                  dr_q   <= dr_q   & wr_data[ST_DR];
                  if (!wr_data[ST_RDF] || !wr_data[ST_DR]) irq_rx_q <= 1'b0;
               end
               SEL_FCTL: fctl_q <= wr_data & FCTL_MASK;
               SEL_PORT: port_q <= wr_data & PORT_MASK;
               default: ;
            endcase
         end
         if (rd_stat && ctrl_q[CTRL_TE]) begin
            tend_q <= 1'b1;
            tde_q  <= 1'b1;
         end
         if (pop_ok) begin
            last_q <= fifo_dout;
            if (!at_trig) rdf_q <= 1'b0;
         end
         if (rx_break) brk_q <= 1'b1;
         if (push_ok) begin
            dr_q <= 1'b1;
            if (at_trig) begin
               rdf_q <= 1'b1;
               if (ctrl_nx[CTRL_RIE]) irq_rx_q <= 1'b1;
            end
         end
      end
   end

   assign tx_byte   = tx_byte_q;
   assign tx_strobe = tx_stb_q;
   assign irq_rx    = irq_rx_q;
   assign irq_tx    = ctrl_q[CTRL_TIE];

   AST_RDF_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok && at_trig |=> rdf_q); // R2
   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_q |-> ctrl_q[CTRL_RIE]); // R2
   AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CTRL_RE] && !rd_rxd && !flush |=> count == $past(count)); // R4
   AST_TXI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> irq_tx == $past(wr_data[CTRL_TIE])); // R5
   AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (reg_sel == SEL_TXD) |=> tx_strobe && (tx_byte == $past(wr_data))); // R9
endmodule

// File: tb/test_serial_rx_trigger_port.sv
module test_serial_rx_trigger_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_sel = 3'd0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'd0;
   logic       rx_break = 1'b0;
   logic [7:0] tx_byte;
   logic       tx_strobe, irq_rx, irq_tx;

   int tests = 0, fails = 0;

   // reference model
   int   m_buf [16];
   int   m_cnt = 0, m_last = 0, m_trig = 1;
   logic [7:0] m_ctrl = 8'h20;
   logic m_tend = 1, m_tde = 1, m_brk = 0, m_rdf = 0, m_dr = 0, m_irq = 0;

   serial_rx_trigger_port i_serial_rx_trigger_port (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_break(rx_break), .tx_byte(tx_byte), .tx_strobe(tx_strobe),
      .irq_rx(irq_rx), .irq_tx(irq_tx));

   always #10 clk = ~clk;

   function automatic int trig_of(input logic [1:0] s);
      case (s)
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 8;
         default: return 14;
      endcase
   endfunction

   function automatic logic [7:0] m_stat();
      return {1'b0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk); reg_sel = s; wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] s, output logic [7:0] v);
      @(negedge clk); reg_sel = s; rd_en = 1'b1;
      #1 v = rd_data;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic check_irqs(input string req);
      chk({req, " irq_rx"}, int'(irq_rx), int'(m_irq));
      chk({req, " irq_tx"}, int'(irq_tx), int'(m_ctrl[7]));
   endtask

   task automatic op_push(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
      if (m_ctrl[4] && m_cnt < 16) begin
         m_buf[m_cnt] = int'(b); m_cnt++; m_dr = 1;
         if (m_cnt >= m_trig) begin
            m_rdf = 1;
            if (m_ctrl[6]) m_irq = 1;
         end
      end
   endtask

   task automatic op_pop(input string req);
      logic [7:0] v;
      int exp;
      bus_rd(3'd3, v);
      exp = (m_cnt != 0) ? m_buf[0] : m_last;
      chk({req, " rx data"}, int'(v), exp);
      if (m_cnt != 0) begin
         m_last = m_buf[0];
         for (int i = 0; i < 15; i++) m_buf[i] = m_buf[i+1];
         m_cnt--;
         if (m_cnt < m_trig) m_rdf = 0;
      end
   endtask

   task automatic op_stat_rd(input string req);
      logic [7:0] v;
      bus_rd(3'd4, v);
      chk({req, " status"}, int'(v), int'(m_stat()));
      if (m_ctrl[5]) begin m_tde = 1; m_tend = 1; end
   endtask

   task automatic op_stat_wr(input logic [7:0] d);
      bus_wr(3'd4, d);
      m_tend &= d[6]; m_tde &= d[5]; m_brk &= d[4]; m_rdf &= d[1]; m_dr &= d[0];
      if (!d[1] || !d[0]) m_irq = 0;
   endtask

   task automatic op_ctrl_wr(input logic [7:0] d);
      bus_wr(3'd1, d);
      m_ctrl = d & 8'hFA;
      if (!d[5]) m_tend = 1;
      if (!d[6]) m_irq = 0;
   endtask

   task automatic op_fctl_wr(input logic [7:0] d);
      bus_wr(3'd5, d);
      m_trig = trig_of(d[7:6]);
      if (d[1]) m_cnt = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      int r;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset values
      chk("R10 irq_rx", int'(irq_rx), 0);
      chk("R10 irq_tx", int'(irq_tx), 0);
      op_stat_rd("R10");
      bus_rd(3'd1, v); chk("R10 ctrl", int'(v), 8'h20);
      bus_rd(3'd0, v); chk("R10 mode", int'(v), 0);
      bus_rd(3'd6, v); chk("R10 port", int'(v), 0);
      bus_rd(3'd5, v); chk("R10 fctl", int'(v), 0);

      // R8 write masks, R11 selects
      bus_wr(3'd0, 8'hFF); bus_rd(3'd0, v); chk("R8 mode mask", int'(v), 8'h7B);
      bus_wr(3'd6, 8'hFF); bus_rd(3'd6, v); chk("R8 port mask", int'(v), 8'hF3);
      op_fctl_wr(8'hFF);   bus_rd(3'd5, v); chk("R8 fctl mask", int'(v), 8'hFD);
      op_ctrl_wr(8'hFF);   bus_rd(3'd1, v); chk("R8 ctrl mask", int'(v), 8'hFA);
      check_irqs("R5");
      // R11 simultaneous write and read acts as write only
      @(negedge clk); reg_sel = 3'd6; wr_data = 8'h10; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
      bus_rd(3'd6, v); chk("R11 write wins", int'(v), 8'h10);

      // R9 transmit path
      bus_wr(3'd2, 8'hA5);
      m_tde = 0;
      chk("R9 tx_strobe", int'(tx_strobe), 1);
      chk("R9 tx_byte", int'(tx_byte), 8'hA5);
      @(negedge clk);
      chk("R9 strobe one cycle", int'(tx_strobe), 0);
      op_stat_rd("R9 tde cleared");
      op_stat_rd("R9 tde restored");

      // R5 control with TE clear sets tend; bit7 drives irq_tx
      op_stat_wr(8'h00);
      op_ctrl_wr(8'h50);
      op_stat_rd("R5 tend set");
      check_irqs("R5");

      // R7 trigger levels, R2 interrupt
      op_ctrl_wr(8'h70);
      for (int s = 0; s < 4; s++) begin
         op_fctl_wr(8'(s << 6) | 8'h02);
         op_stat_wr(8'h00);
         for (int k = 0; k < trig_of(2'(s)) - 1; k++) op_push(8'(k + 16*s));
         chk("R7 below level irq", int'(irq_rx), 0);
         op_stat_rd("R7 below level");
         op_push(8'hEE);
         chk("R7 at level irq", int'(irq_rx), 1);
         op_stat_rd("R2 at level");
      end
      // R3 pop below level clears data-full; R6 clear-by-zero drops irq
      op_pop("R3"); op_stat_rd("R3 rdf cleared");
      op_stat_wr(8'hFD); check_irqs("R6");
      op_stat_rd("R6 after clear");

      // R2 no irq with enable off
      op_ctrl_wr(8'h30);
      op_fctl_wr(8'h02);
      op_push(8'h11);
      chk("R2 irq gated", int'(irq_rx), 0);
      op_stat_rd("R2 rdf without irq");

      // R1 overflow and order; R3 empty read
      op_fctl_wr(8'hC2);
      for (int k = 0; k < 18; k++) op_push(8'(k + 8'h40));
      for (int k = 0; k < 16; k++) op_pop("R1");
      op_pop("R3 empty read");
      op_pop("R3 empty read again");

      // R4 receive disabled
      op_ctrl_wr(8'h20);
      op_push(8'h99);
      op_pop("R4 ignored byte");
      op_stat_rd("R4");

      // R6 break
      op_stat_wr(8'h00);
      @(negedge clk); rx_break = 1'b1;
      @(negedge clk); rx_break = 1'b0;
      m_brk = 1;
      op_stat_rd("R6 break");
      op_stat_wr(8'hEF);
      op_stat_rd("R6 break cleared");

      // random mix against the model
      op_ctrl_wr(8'hF0);
      for (int n = 0; n < 600; n++) begin
         r = int'($urandom_range(0, 99));
         if (r < 40)      op_push(8'($urandom));
         else if (r < 70) op_pop("R1 R3 random");
         else if (r < 80) op_stat_rd("R6 random");
         else if (r < 87) op_stat_wr(8'($urandom) | 8'h02);
         else if (r < 94) op_ctrl_wr(8'($urandom) | 8'h10);
         else             op_fctl_wr(8'($urandom) & ((($urandom & 3) == 0) ? 8'hFF : 8'hFD));
         check_irqs("R2 R5 random");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule